// File: doc/BRIEF.md
# Byte-Masked Burst Write Assembler

This block assembles one four-word write burst arriving over a double-data-rate write path and commits it to a small synchronous array. An upstream arbiter supplies a single-cycle start strobe and a burst address. On each of the two following clock cycles, two words arrive side by side: the word captured on the rising clock edge and the word captured on the inverted-clock edge. Each word carries its own active-low lane selects, one per 9-bit lane.

The words and their per-lane enables are merged into a four-word staging register. On the edge after the last pair lands, all four words go into the array as one entry, and only the enabled lanes are written. Lanes whose select was deasserted keep whatever the array already held. The staging register and its lane enables are exported so that a neighbouring read path can forward data that has not been committed yet. A plain read port on the array lets that neighbour, or a test, observe committed contents.

Top module: `burst_wr_assembler`

## Requirements
- R1: A start strobe is accepted on a rising edge unless a burst was accepted on the immediately preceding edge; an accepted start latches `wr_addr` as the burst address.
- R2: For a burst accepted at edge E0, words 0 and 1 are taken from `rise_data`/`fall_data` at edge E1, and words 2 and 3 are taken from the same pair at edge E2.
- R3: Each word has its own active-low select vector, sampled on the same edge as that word. Select bit i governs bits [9i+8:9i] of the word.
- R4: In an array lane whose select was high for that word, the previously stored value is left unchanged; enabled lanes take the new data.
- R5: During the cycle after E2, `commit_valid` is high and `commit_addr` shows the burst address. At edge E3 the array entry is written as one 72-bit unit, with word k at bits [18k+17:18k].
- R6: A start presented on the edge right after an accepted start is ignored. A start two edges later is accepted, which gives back-to-back bursts without mixing their data or addresses.
- R7: On edges outside a burst's two data cycles, the data and select inputs are ignored: the staging register, the lane enables and the array do not change.
- R8: `stage_data` holds word k at bits [18k+17:18k]. `stage_lane_we` holds the active-high enable of word k, lane i, at bit 2k+i.
- R9: With the registered read option, `rd_data` shows the array entry at `rd_addr` one edge after the address is presented, in the R5 layout.
- R10: After reset, `commit_valid`, `stage_data`, `stage_lane_we` and `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | Burst start strobe from the arbiter |
| wr_addr | input | ADDR_W | Burst address, sampled with an accepted start |
| rise_data | input | LANE_W*LANES | Rising-edge word of the current pair |
| rise_sel_n | input | LANES | Active-low lane selects for the rising-edge word |
| fall_data | input | LANE_W*LANES | Inverted-edge word of the current pair |
| fall_sel_n | input | LANES | Active-low lane selects for the inverted-edge word |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 4*LANE_W*LANES | Array entry at the read address |
| commit_valid | output | 1 | Staging is being committed on the coming edge |
| commit_addr | output | ADDR_W | Address being committed |
| stage_data | output | 4*LANE_W*LANES | Staging register, four words |
| stage_lane_we | output | 4*LANES | Per-word, per-lane write enables in staging |

## Verification
The bench builds the block with two 9-bit lanes and a 2-bit address, so the array has four entries. This makes it possible to sweep every one of the 256 combinations of the eight per-word lane selects, rotating through all four addresses. Each sweep step is checked against an arithmetic model of the array. The small depth also lets every entry be read back after the overlapping-start and idle-garbage sequences, and the registered read option is the one exercised.

// File: rtl/burst_asm_pkg.sv
package burst_asm_pkg;
   localparam int BURST_WORDS   = 4;
   localparam int WORDS_PER_CYC = 2;

   // active-low selects to active-high lane enables
   function automatic logic [7:0] sel_to_we(input logic [7:0] sel_n);
      return ~sel_n;
   endfunction
endpackage

// File: rtl/burst_seq.sv
module burst_seq #(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_start,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic              pair_lo,
   output logic              pair_hi,
   output logic              commit_valid,
   output logic [ADDR_W-1:0] commit_addr
);
   logic              accept;
   logic [ADDR_W-1:0] burst_addr;

   assign accept = wr_start && !pair_lo;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pair_lo      <= 1'b0;
         pair_hi      <= 1'b0;
         commit_valid <= 1'b0;
         burst_addr   <= '0;
         commit_addr  <= '0;
      end else begin
         pair_lo      <= accept;
         pair_hi      <= pair_lo;
         commit_valid <= pair_hi;
         if (accept)  burst_addr  <= wr_addr;
         if (pair_hi) commit_addr <= burst_addr;
      end
   end
endmodule

// File: rtl/stage_reg.sv
module stage_reg #(
   parameter int LANE_W = 9,
   parameter int LANES  = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            pair_lo,
   input  logic                            pair_hi,
   input  logic [LANE_W*LANES-1:0]         rise_data,
   input  logic [LANES-1:0]                rise_sel_n,
   input  logic [LANE_W*LANES-1:0]         fall_data,
   input  logic [LANES-1:0]                fall_sel_n,
   output logic [4*LANE_W*LANES-1:0]       stage_data,
   output logic [4*LANES-1:0]              stage_lane_we
);
   import burst_asm_pkg::*;
   localparam int WORD_W = LANE_W * LANES;

   for (genvar w = 0; w < BURST_WORDS; w++) begin : g_word
      logic                  load;
      logic [WORD_W-1:0]     din;
      logic [LANES-1:0]      sel_n;

      if (w / WORDS_PER_CYC == 0) begin : g_lo
         assign load = pair_lo;
      end else begin : g_hi
         assign load = pair_hi;
      end

      if (w % WORDS_PER_CYC == 0) begin : g_rise
         assign din   = rise_data;
         assign sel_n = rise_sel_n;
      end else begin : g_fall
         assign din   = fall_data;
         assign sel_n = fall_sel_n;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stage_data[w*WORD_W +: WORD_W]   <= '0;
            stage_lane_we[w*LANES +: LANES]  <= '0;
         end else if (load) begin
            stage_data[w*WORD_W +: WORD_W]   <= din;
            stage_lane_we[w*LANES +: LANES]  <= ~sel_n;
         end
      end
   end
endmodule

// File: rtl/lane_mem.sv
module lane_mem #(
   parameter int LANE_W  = 9,
   parameter int N_LANES = 8,
   parameter int ADDR_W  = 4,
   parameter bit RD_REG  = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [N_LANES*LANE_W-1:0]   wr_data,
   input  logic [N_LANES-1:0]          lane_we,
   input  logic [ADDR_W-1:0]           rd_addr,
   output logic [N_LANES*LANE_W-1:0]   rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [N_LANES*LANE_W-1:0] rd_comb;

   for (genvar l = 0; l < N_LANES; l++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && lane_we[l])
            cells[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
      end

      assign rd_comb[l*LANE_W +: LANE_W] = cells[rd_addr];
   end

   if (RD_REG) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= rd_comb;
      end
   end else begin : g_rd_comb
      assign rd_data = rd_comb;
   end
endmodule

// File: rtl/burst_wr_assembler.sv
module burst_wr_assembler #(
   parameter int LANE_W = 9,
   parameter int LANES  = 2,
   parameter int ADDR_W = 4,
   parameter bit RD_REG = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_start,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [LANE_W*LANES-1:0]       rise_data,
   input  logic [LANES-1:0]              rise_sel_n,
   input  logic [LANE_W*LANES-1:0]       fall_data,
   input  logic [LANES-1:0]              fall_sel_n,
   input  logic [ADDR_W-1:0]             rd_addr,
   output logic [4*LANE_W*LANES-1:0]     rd_data,
   output logic                          commit_valid,
   output logic [ADDR_W-1:0]             commit_addr,
   output logic [4*LANE_W*LANES-1:0]     stage_data,
   output logic [4*LANES-1:0]            stage_lane_we
);
   import burst_asm_pkg::*;
   localparam int ENT_LANES = BURST_WORDS * LANES;

   if (LANE_W < 1 || LANE_W > 64) begin : g_bad_lane_w
      $error("burst_wr_assembler: LANE_W out of range");
   end
   if (LANES < 1 || LANES > 8) begin : g_bad_lanes
      $error("burst_wr_assembler: LANES out of range");
   end
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr_w
      $error("burst_wr_assembler: ADDR_W out of range");
   end

   logic pair_lo, pair_hi;

   burst_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_start     (wr_start),
      .wr_addr      (wr_addr),
      .pair_lo      (pair_lo),
      .pair_hi      (pair_hi),
      .commit_valid (commit_valid),
      .commit_addr  (commit_addr)
   );

   stage_reg #(.LANE_W(LANE_W), .LANES(LANES)) u_stage (
      .clk           (clk),
      .rst_n         (rst_n),
      .pair_lo       (pair_lo),
      .pair_hi       (pair_hi),
      .rise_data     (rise_data),
      .rise_sel_n    (rise_sel_n),
      .fall_data     (fall_data),
      .fall_sel_n    (fall_sel_n),
      .stage_data    (stage_data),
      .stage_lane_we (stage_lane_we)
   );

   lane_mem #(
      .LANE_W (LANE_W),
      .N_LANES(ENT_LANES),
      .ADDR_W (ADDR_W),
      .RD_REG (RD_REG)
   ) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (commit_valid),
      .wr_addr (commit_addr),
      .wr_data (stage_data),
      .lane_we (stage_lane_we),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );
endmodule

// File: rtl/burst_asm_chk.sv
module burst_asm_chk #(
   parameter int LANE_W = 9,
   parameter int LANES  = 2,
   parameter int ADDR_W = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      wr_start,
   input logic [ADDR_W-1:0]         wr_addr,
   input logic [LANES-1:0]          rise_sel_n,
   input logic [LANES-1:0]          fall_sel_n,
   input logic                      commit_valid,
   input logic [ADDR_W-1:0]         commit_addr,
   input logic [4*LANE_W*LANES-1:0] stage_data,
   input logic [4*LANES-1:0]        stage_lane_we
);
   logic              s_a, s_b;
   logic [ADDR_W-1:0] s_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_a    <= 1'b0;
         s_b    <= 1'b0;
         s_addr <= '0;
      end else begin
         s_a <= wr_start && !s_a;
         s_b <= s_a;
         if (wr_start && !s_a) s_addr <= wr_addr;
      end
   end

   p_commit_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
      s_b |=> (commit_valid && commit_addr == $past(s_addr)));

   p_no_spurious_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !s_b |=> !commit_valid);

   p_commit_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid |=> !commit_valid);

   p_first_pair_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      s_a |=> (stage_lane_we[LANES-1:0] == ~$past(rise_sel_n) &&
               stage_lane_we[2*LANES-1:LANES] == ~$past(fall_sel_n)));

   p_idle_stage_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!s_a && !s_b) |=> ($stable(stage_data) && $stable(stage_lane_we)));
endmodule

bind burst_wr_assembler burst_asm_chk #(
   .LANE_W(LANE_W), .LANES(LANES), .ADDR_W(ADDR_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_start      (wr_start),
   .wr_addr       (wr_addr),
   .rise_sel_n    (rise_sel_n),
   .fall_sel_n    (fall_sel_n),
   .commit_valid  (commit_valid),
   .commit_addr   (commit_addr),
   .stage_data    (stage_data),
   .stage_lane_we (stage_lane_we)
);

// File: tb/tb_burst_wr_assembler.sv
module tb_burst_wr_assembler;
   localparam int CLK_PERIOD = 10;
   localparam int LW = 9;
   localparam int LN = 2;
   localparam int AW = 2;
   localparam int WW = LW * LN;
   localparam int EW = 4 * WW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_start = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [WW-1:0] rise_data = '0, fall_data = '0;
   logic [LN-1:0] rise_sel_n = '1, fall_sel_n = '1;
   logic [AW-1:0] rd_addr = '0;
   logic [EW-1:0] rd_data, stage_data;
   logic          commit_valid;
   logic [AW-1:0] commit_addr;
   logic [4*LN-1:0] stage_lane_we;

   int n_checks = 0, n_fail = 0;
   bit done = 0;
   logic [EW-1:0] model [4];

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_wr_assembler #(.LANE_W(LW), .LANES(LN), .ADDR_W(AW), .RD_REG(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
      .rise_data(rise_data), .rise_sel_n(rise_sel_n),
      .fall_data(fall_data), .fall_sel_n(fall_sel_n),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .commit_valid(commit_valid), .commit_addr(commit_addr),
      .stage_data(stage_data), .stage_lane_we(stage_lane_we)
   );

   task automatic chk(input bit ok, input string req, input logic [EW-1:0] act, input logic [EW-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [WW-1:0] dgen(input int seed, input int k);
      int v;
      v = seed * 97 + k * 4099 + 13 + seed * k * 7;
      return v[WW-1:0];
   endfunction

   function automatic void model_write(input logic [AW-1:0] a, input logic [WW-1:0] d [4],
                                       input logic [LN-1:0] s [4]);
      for (int k = 0; k < 4; k++)
         for (int l = 0; l < LN; l++)
            if (!s[k][l]) model[a][k*WW + l*LW +: LW] = d[k][l*LW +: LW];
   endfunction

   task automatic garbage(input int seed);
      rise_data  = dgen(seed, 11); fall_data = dgen(seed, 12);
      rise_sel_n = '0;             fall_sel_n = '0;
   endtask

   // one burst; returns at the negedge after the commit edge
   task automatic burst(input logic [AW-1:0] a, input logic [WW-1:0] d [4], input logic [LN-1:0] s [4]);
      logic [4*LN-1:0] exp_we;
      logic [EW-1:0]   exp_sd;
      wr_start = 1'b1; wr_addr = a;
      @(negedge clk);
      wr_start = 1'b0; wr_addr = ~a;
      rise_data = d[0]; rise_sel_n = s[0]; fall_data = d[1]; fall_sel_n = s[1];
      @(negedge clk);
      rise_data = d[2]; rise_sel_n = s[2]; fall_data = d[3]; fall_sel_n = s[3];
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
         exp_we[k*LN +: LN] = ~s[k];
         exp_sd[k*WW +: WW] = d[k];
      end
      chk(commit_valid === 1'b1, "R5 commit_valid", EW'(commit_valid), EW'(1));
      chk(commit_addr === a, "R5 commit_addr", EW'(commit_addr), EW'(a));
      chk(stage_data === exp_sd, "R2/R8 stage_data", stage_data, exp_sd);
      chk(stage_lane_we === exp_we, "R3/R8 stage_lane_we", EW'(stage_lane_we), EW'(exp_we));
      garbage(a + 5);
      @(negedge clk);
      model_write(a, d, s);
   endtask

   task automatic read_chk(input logic [AW-1:0] a, input string req);
      rd_addr = a;
      @(negedge clk);
      chk(rd_data === model[a], req, rd_data, model[a]);
   endtask

   initial begin
      logic [WW-1:0] d [4];
      logic [LN-1:0] s [4];
      logic [EW-1:0] sd_hold;
      logic [4*LN-1:0] we_hold;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(commit_valid === 1'b0, "R10 commit_valid", EW'(commit_valid), '0);
      chk(stage_data === '0, "R10 stage_data", stage_data, '0);
      chk(stage_lane_we === '0, "R10 stage_lane_we", EW'(stage_lane_we), '0);
      chk(rd_data === '0, "R10 rd_data", rd_data, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // fill every entry fully
      for (int a = 0; a < 4; a++) begin
         model[a] = '0;
         for (int k = 0; k < 4; k++) begin d[k] = dgen(a + 300, k); s[k] = '0; end
         burst(AW'(a), d, s);
      end
      for (int a = 0; a < 4; a++) read_chk(AW'(a), "R9 full write readback");

      // R4: sweep all 256 per-word lane select combinations
      for (int m = 0; m < 256; m++) begin
         for (int k = 0; k < 4; k++) begin d[k] = dgen(m, k); s[k] = LN'(m >> (2*k)); end
         burst(AW'(m), d, s);
         read_chk(AW'(m), "R4 masked lanes keep array contents");
      end

      // R6: start on next edge ignored, start two edges later accepted
      wr_start = 1'b1; wr_addr = 2'd1;
      @(negedge clk);
      wr_start = 1'b1; wr_addr = 2'd2;            // ignored
      rise_data = 18'h11111; fall_data = 18'h22222; rise_sel_n = '0; fall_sel_n = '0;
      @(negedge clk);
      wr_start = 1'b1; wr_addr = 2'd3;            // accepted
      rise_data = 18'h33333; fall_data = 18'h04444; rise_sel_n = 2'b10; fall_sel_n = '0;
      @(negedge clk);
      chk(commit_valid === 1'b1, "R6 first burst commits", EW'(commit_valid), EW'(1));
      chk(commit_addr === 2'd1, "R6 first burst address", EW'(commit_addr), EW'(1));
      wr_start = 1'b0;
      rise_data = 18'h05555; fall_data = 18'h06666; rise_sel_n = '0; fall_sel_n = 2'b01;
      @(negedge clk);
      chk(commit_valid === 1'b0, "R6 no commit for ignored start", EW'(commit_valid), '0);
      rise_data = 18'h07777; fall_data = 18'h08888; rise_sel_n = '0; fall_sel_n = '0;
      @(negedge clk);
      chk(commit_valid === 1'b1, "R6 second burst commits", EW'(commit_valid), EW'(1));
      chk(commit_addr === 2'd3, "R6 second burst address", EW'(commit_addr), EW'(3));
      garbage(77);
      @(negedge clk);
      d[0] = 18'h11111; d[1] = 18'h22222; d[2] = 18'h33333; d[3] = 18'h04444;
      s[0] = '0; s[1] = '0; s[2] = 2'b10; s[3] = '0;
      model_write(2'd1, d, s);
      d[0] = 18'h05555; d[1] = 18'h06666; d[2] = 18'h07777; d[3] = 18'h08888;
      s[0] = '0; s[1] = 2'b01; s[2] = '0; s[3] = '0;
      model_write(2'd3, d, s);
      read_chk(2'd1, "R6 first burst data");
      read_chk(2'd2, "R6 ignored start left entry unchanged");
      read_chk(2'd3, "R6 second burst data");

      // R7: idle garbage ignored
      sd_hold = stage_data; we_hold = stage_lane_we;
      for (int i = 0; i < 8; i++) begin
         garbage(i + 900);
         @(negedge clk);
      end
      chk(stage_data === sd_hold, "R7 idle stage_data", stage_data, sd_hold);
      chk(stage_lane_we === we_hold, "R7 idle stage_lane_we", EW'(stage_lane_we), EW'(we_hold));
      chk(commit_valid === 1'b0, "R7 idle no commit", EW'(commit_valid), '0);
      for (int a = 0; a < 4; a++) read_chk(AW'(a), "R7 idle array unchanged");

      // R1: start from idle after long gap accepted
      for (int k = 0; k < 4; k++) begin d[k] = dgen(555, k); s[k] = '0; end
      burst(2'd0, d, s);
      read_chk(2'd0, "R1 start accepted from idle");

      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule